// File: doc/BRIEF.md
# Two-Key Timebase Watchdog

This block is a watchdog peripheral with a small word-wide register port. A free-running 32-bit timebase counter runs from power-on reset and can be read back, so software can confirm the clock is alive. A separate interval counter runs only while two arm bits are both set, one in each control register. Every time that counter completes a window of 2^INTERVAL_LOG2 cycles, a two-step escalation moves forward. The first unserviced window raises a pending flag and a one-cycle interrupt. The second asserts a system reset output and latches a reset-cause flag.

Software services the watchdog by writing ones to either flag bit. This clears the flag that was written and starts the window again. To disarm, software clears either arm bit, and counting then stops with the window position cleared. A build option locks the first arm bit once it is set, so that only a power-on reset can disarm the block. The reset output is stretched to a fixed length. The reset-cause flag is independent of that output, so it can still be read after the system comes back up.

Top module: `dual_arm_watchdog`

## Requirements
- R1: After power-on reset (`rst_n` low), both control registers read 0 and `wd_irq` and `wd_reset_out` are low.
- R2: Register layout by byte address: 0x0 holds the reset-cause flag in bit 3, the pending flag in bit 2 and arm bit A in bit 1. 0x4 holds arm bit B in bit 0. 0x8 is the timebase. All other bits and addresses read 0.
- R3: The timebase advances by one every clock cycle from power-on reset and wraps at 32 bits. Writes to 0x8 have no effect on it.
- R4: The window counts only while arm A and arm B are both 1. Clearing either arm bit stops counting and discards the window position, but the flags keep their values.
- R5: When arming completes with a write in cycle c, the first expiry sets the pending flag and drives `wd_irq` high for exactly cycle c+1+2^INTERVAL_LOG2.
- R6: An expiry while the pending flag is set sets the reset-cause flag and drives `wd_reset_out` high for RST_HOLD consecutive cycles (16 by default). With no servicing, the reset starts in cycle c+1+2^(INTERVAL_LOG2+1).
- R7: Writing 1 to bit 2 or bit 3 of 0x0 clears the matching flag and restarts the window. A restart in the same cycle as an expiry suppresses that expiry.
- R8: The reset-cause flag stays set after `wd_reset_out` drops. Only writing 1 to it or a power-on reset clears it.
- R9: With STICKY_ARM=1, once arm A is 1, writing 0 to it leaves it at 1. With STICKY_ARM=0 the write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_wen | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wd_irq | output | 1 | One-cycle pulse on the first expiry |
| wd_reset_out | output | 1 | Stretched system reset request |

## Verification
The bench builds two instances on one shared register port. The first uses INTERVAL_LOG2=5 and STICKY_ARM=0. Its 32-cycle window brings both escalation steps, a restart timed into the exact expiry cycle, a disarm and re-arm with the pending flag left set, and the full 16-cycle reset hold within a few hundred cycles. The second uses INTERVAL_LOG2=4 and STICKY_ARM=1, and is read only to compare the locked arm bit against the unlocked one.

// File: rtl/dawd_pkg.sv
package dawd_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CTL0 = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CTL1 = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_TB   = 4'h8;

  localparam int B_RFLAG = 3;
  localparam int B_STATE = 2;
  localparam int B_ARMA  = 1;
  localparam int B_ARMB  = 0;

  function automatic logic [DATA_W-1:0] pack_ctl0(input logic rflag, input logic state,
                                                  input logic arm_a);
    logic [DATA_W-1:0] v;
    v = '0;
    v[B_RFLAG] = rflag;
    v[B_STATE] = state;
    v[B_ARMA]  = arm_a;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctl1(input logic arm_b);
    logic [DATA_W-1:0] v;
    v = '0;
    v[B_ARMB] = arm_b;
    return v;
  endfunction
endpackage

// File: rtl/dawd_timebase.sv
module dawd_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] tb_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_q <= '0;
    else        tb_q <= tb_q + W'(1);
  end

  // R3
  tb_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tb_q == $past(tb_q) + W'(1));
endmodule

// File: rtl/dawd_interval.sv
module dawd_interval #(
  parameter int LOG2 = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic restart,
  output logic expire
);
  logic [LOG2-1:0] iv_q;

  assign expire = armed && !restart && (iv_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 iv_q <= '0;
    else if (!armed || restart) iv_q <= '0;
    else                        iv_q <= iv_q + LOG2'(1);
  end

  // R4
  iv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !expire);
endmodule

// File: rtl/dawd_stage.sv
module dawd_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_state,
  input  logic clr_rflag,
  output logic state_q,
  output logic rflag_q,
  output logic irq_q,
  output logic bite
);
  logic warn;
  assign warn = expire && !state_q;
  assign bite = expire && state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      rflag_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= warn;
      if (clr_state) state_q <= 1'b0;
      else if (warn) state_q <= 1'b1;
      if (clr_rflag) rflag_q <= 1'b0;
      else if (bite) rflag_q <= 1'b1;
    end
  end

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R8
  rflag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rflag_q && !clr_rflag |=> rflag_q);
endmodule

// File: rtl/dawd_rst_hold.sv
module dawd_rst_hold #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_o
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (fire)           cnt_q <= CW'(HOLD);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign rst_o = (cnt_q != '0);

  // R6
  rst_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |=> rst_o);
endmodule

// File: rtl/dual_arm_watchdog.sv
module dual_arm_watchdog
  import dawd_pkg::*;
#(
  parameter int INTERVAL_LOG2 = 20,
  parameter int RST_HOLD      = 16,
  parameter bit STICKY_ARM    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_irq,
  output logic              wd_reset_out
);
  logic wr_ctl0, wr_ctl1;
  logic clr_state, clr_rflag, restart;
  logic arm_a, arm_b, armed;
  logic expire, state_q, rflag_q, bite;
  logic [DATA_W-1:0] tb_q;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:B_RFLAG+1];

  assign wr_ctl0   = bus_wen && (bus_addr == OFS_CTL0);
  assign wr_ctl1   = bus_wen && (bus_addr == OFS_CTL1);
  assign clr_state = wr_ctl0 && bus_wdata[B_STATE];
  assign clr_rflag = wr_ctl0 && bus_wdata[B_RFLAG];
  assign restart   = clr_state || clr_rflag;
  assign armed     = arm_a && arm_b;

  generate
    if (STICKY_ARM) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       arm_a <= 1'b0;
        else if (wr_ctl0) arm_a <= arm_a | bus_wdata[B_ARMA];
      end
      // R9
      arm_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_a |=> arm_a);
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       arm_a <= 1'b0;
        else if (wr_ctl0) arm_a <= bus_wdata[B_ARMA];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       arm_b <= 1'b0;
    else if (wr_ctl1) arm_b <= bus_wdata[B_ARMB];
  end

  dawd_timebase #(.W(DATA_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tb_q(tb_q));

  dawd_interval #(.LOG2(INTERVAL_LOG2)) u_iv (
    .clk(clk), .rst_n(rst_n), .armed(armed), .restart(restart), .expire(expire));

  dawd_stage u_stage (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr_state(clr_state),
    .clr_rflag(clr_rflag), .state_q(state_q), .rflag_q(rflag_q),
    .irq_q(wd_irq), .bite(bite));

  dawd_rst_hold #(.HOLD(RST_HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .fire(bite), .rst_o(wd_reset_out));

  always_comb begin
    case (bus_addr)
      OFS_CTL0: bus_rdata = pack_ctl0(rflag_q, state_q, arm_a);
      OFS_CTL1: bus_rdata = pack_ctl1(arm_b);
      OFS_TB:   bus_rdata = tb_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R4
  no_arm_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !wd_irq);
  // R7
  kick_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !wd_irq);
  // R6
  bite_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_reset_out) |-> rflag_q);
endmodule

// File: tb/dual_arm_watchdog_bench.sv
module dual_arm_watchdog_bench;
  localparam int N    = 5;
  localparam int IV   = 1 << N;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wen = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata_s;
  logic wd_irq, wd_reset_out, irq_s, rst_s;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int irq_q[$];
  int rst_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_arm_watchdog #(.INTERVAL_LOG2(N), .RST_HOLD(HOLD), .STICKY_ARM(1'b0)) u_dual_arm_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_irq(wd_irq),
    .wd_reset_out(wd_reset_out));

  dual_arm_watchdog #(.INTERVAL_LOG2(4), .RST_HOLD(HOLD), .STICKY_ARM(1'b1)) u_sticky (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .wd_irq(irq_s),
    .wd_reset_out(rst_s));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  function automatic int irq_cycle(input int wcyc);
    return wcyc + 1 + IV;
  endfunction

  function automatic int bite_cycle(input int wcyc);
    return wcyc + 1 + 2 * IV;
  endfunction

  task automatic at_cycle(input int n);
    while (cyc < n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input int n, input logic [3:0] a, input logic [31:0] d);
    at_cycle(n);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wen = 1'b0;
  endtask

  task automatic rd(input int n, input logic [3:0] a, output logic [31:0] d);
    at_cycle(n);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // Monitor: pops expected output events from the scoreboard queues.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_irq, exp_rst;
      exp_irq = (irq_q.size() > 0) && (irq_q[0] == cyc);
      chk("R5 irq", {31'b0, wd_irq}, {31'b0, exp_irq});
      if (exp_irq) void'(irq_q.pop_front());
      exp_rst = (rst_q.size() > 0) && (cyc >= rst_q[0]) && (cyc < rst_q[0] + HOLD);
      chk("R6 reset_out", {31'b0, wd_reset_out}, {31'b0, exp_rst});
      if ((rst_q.size() > 0) && (cyc >= rst_q[0] + HOLD - 1)) void'(rst_q.pop_front());
    end
  end

  initial begin
    logic [31:0] v, v2;
    int c, k, t, r, s;
    at_cycle(5);
    rst_n = 1'b1;
    // R1 reset state
    rd(6, 4'h0, v);  chk("R1 ctl0", v, 32'h0);
    rd(7, 4'h4, v);  chk("R1 ctl1", v, 32'h0);
    chk("R1 outputs", {30'b0, wd_irq, wd_reset_out}, 32'h0);
    // R2 unmapped address
    rd(8, 4'hC, v);  chk("R2 unmapped", v, 32'h0);
    // R3 timebase advances, write ignored
    rd(20, 4'h8, v);
    wr(22, 4'h8, 32'h0);
    rd(25, 4'h8, v2); chk("R3 timebase", v2, v + 32'd5);
    // R4 only arm A: no counting
    wr(30, 4'h0, 32'h2);
    rd(120, 4'h0, v); chk("R2 R4 ctl0 arm A", v, 32'h2);
    rd(121, 4'h4, v); chk("R4 ctl1", v, 32'h0);
    // arm B: first and second expiry
    c = 130;
    irq_q.push_back(irq_cycle(c));
    rst_q.push_back(bite_cycle(c));
    wr(c, 4'h4, 32'h1);
    rd(c + 2, 4'h4, v);  chk("R2 ctl1 arm B", v, 32'h1);
    rd(c + 40, 4'h0, v); chk("R5 pending flag", v, 32'h6);
    rd(c + 70, 4'h0, v); chk("R6 reset-cause flag", v, 32'hE);
    rd(c + 85, 4'h0, v); chk("R8 flag persists", v, 32'hE);
    // R7 service clears both flags
    k = c + 88;
    irq_q.push_back(irq_cycle(k));
    wr(k, 4'h0, 32'hE);
    rd(k + 2, 4'h0, v);  chk("R7 R8 flags cleared", v, 32'h2);
    // R7 restart in the exact expiry cycle
    t = irq_cycle(k);
    irq_q.push_back(t + 64);
    wr(t + 31, 4'h0, 32'h6);
    rd(t + 33, 4'h0, v); chk("R7 collision no bite", v, 32'h2);
    // R4 disarm keeps flags, re-arm restarts window
    wr(t + 70, 4'h4, 32'h0);
    rd(t + 200, 4'h0, v); chk("R4 flags kept while disarmed", v, 32'h6);
    rd(t + 201, 4'h4, v); chk("R4 arm B cleared", v, 32'h0);
    r = t + 202;
    rst_q.push_back(r + 1 + IV);
    wr(r, 4'h4, 32'h1);
    rd(r + 40, 4'h0, v); chk("R6 bite after re-arm", v, 32'hE);
    wr(r + 60, 4'h0, 32'hC);
    rd(r + 62, 4'h0, v); chk("R7 clear and disarm", v, 32'h0);
    // R9 sticky arm bit
    s = r + 150;
    wr(s, 4'h0, 32'h2);
    wr(s + 2, 4'h0, 32'h0);
    rd(s + 4, 4'h0, v);
    chk("R9 plain arm A clears", v & 32'h2, 32'h0);
    chk("R9 sticky arm A holds", rdata_s & 32'h2, 32'h2);
    at_cycle(s + 20);
    chk("R5 R6 scoreboard drained", irq_q.size() + rst_q.size(), 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: bench hung at cycle %0d, expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule